// File: doc/BRIEF.md
# Table-Programmed Serial Flash Sequencer

This block runs one short instruction program against a serial flash that can use one, two or four data lines. Software first fills a sequence table with 32-bit words. Each word holds two 16-bit instructions, so one sequence of four words holds up to eight instructions. A single write to the command port picks a sequence and a data byte count, and that write also starts the run.

The sequencer then asserts chip select. It fetches the instructions one by one and turns each into serial beats. A beat is one cycle with the flash clock enable high, during which the data lines are driven or sampled. Opcode bytes, address bytes and mode bytes are sent from the instruction operand. Dummy instructions add idle clocks. Data instructions move the counted number of bytes between the pins and two byte FIFOs: one for transmit and one for receive.

The run ends on a stop instruction, on an unknown opcode, or after the eighth instruction. At that point the sequencer releases chip select and sets a done flag. Software clears the flag by writing 1 to it. The flag also drives an interrupt when the interrupt is enabled.

Top module: `flash_seq_engine`

## Requirements
- R1: An instruction has its opcode in bits [15:10], its lane code in [9:8] and its operand in [7:0]. Instruction k of sequence s sits in table word s*4 + k/2: even k in bits [15:0], odd k in bits [31:16].
- R2: A command write starts a run when the block is idle. The sequence index is taken from cmd_wdata[31:24] and the byte count from cmd_wdata[CNT_W-1:0]. A command write while busy is ignored.
- R3: Opcodes 1 (command), 2 (address) and 4 (mode) each send their operand byte, MSB first. Lane code 0 uses io_out[0] with 8 beats. Lane code 1 uses io_out[1:0], higher bit on io_out[1], with 4 beats. Lane codes 2 and 3 use io_out[3:0], upper nibble first, with 2 beats. io_oe shows exactly the lanes in use.
- R4: Opcode 3 (dummy) gives as many beats as its operand says, capped at 64, with io_oe at zero. An operand of 0 gives no beats.
- R5: Opcode 7 (read) receives the counted number of bytes into the receive FIFO, MSB first. It samples io_in[1] on one lane, io_in[1:0] on two lanes and io_in[3:0] on four lanes.
- R6: Opcode 8 (write) sends the counted number of bytes from the transmit FIFO, in push order. While that FIFO is empty, no beats are produced.
- R7: Opcode 0, or any opcode not listed above, ends the run. So does finishing instruction 7. Chip select rises one clock after the ending point.
- R8: The done flag is set when chip select is released. Writing flag_wbit=1 with flag_we clears it; writing 0 has no effect. irq is high while the flag and irq_en are both high.
- R9: busy is high from the clock after the starting command write until chip select is released, and is high whenever chip select is low.
- R10: sck_en is high only while chip select is low, and io_oe is zero whenever chip select is high.
- R11: A read or write instruction with a byte count of zero produces no beats and moves no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Sequence table write enable |
| tbl_waddr | input | IDX_W+2 | Table word address |
| tbl_wdata | input | 32 | Table word (two instructions) |
| cmd_we | input | 1 | Command write, starts a run |
| cmd_wdata | input | 32 | Sequence index [31:24], byte count in low bits |
| busy | output | 1 | Command-driven access in progress |
| flag_we | input | 1 | Flag register write |
| flag_wbit | input | 1 | Value written to flag bit 0 (1 clears) |
| irq_en | input | 1 | Interrupt enable for the done flag |
| done | output | 1 | Transaction-finished flag |
| irq | output | 1 | Interrupt request |
| tx_push | input | 1 | Push into transmit FIFO |
| tx_data | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Pop from receive FIFO |
| rx_data | output | 8 | Head of receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| cs_n | output | 1 | Flash chip select, active low |
| sck_en | output | 1 | Flash clock enable, one beat per high cycle |
| io_out | output | 4 | Data lines driven to flash |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Data lines from flash |

## Verification
The assertions check the pin-level rules on every cycle:
- the clock enable and the output enables stay off outside chip select;
- the enable pattern is always a legal lane set;
- busy covers the whole chip-select window and rises only after a command write;
- chip select rises only together with the done flag;
- the flag falls only after a write of 1.

Only the bench scenarios can show the following:
- the bit order and lane mapping of sent and received bytes;
- the beat counts of dummy phases, including the 64 cap;
- how instructions are packed in the table;
- the stall on an empty transmit FIFO;
- ending on an unknown opcode or after the eighth instruction;
- that a command issued during a run is dropped.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam logic [5:0] OP_STOP  = 6'd0;
  localparam logic [5:0] OP_CMD   = 6'd1;
  localparam logic [5:0] OP_ADDR  = 6'd2;
  localparam logic [5:0] OP_DUMMY = 6'd3;
  localparam logic [5:0] OP_MODE  = 6'd4;
  localparam logic [5:0] OP_READ  = 6'd7;
  localparam logic [5:0] OP_WRITE = 6'd8;

  localparam int INSTR_PER_SEQ = 8;
  localparam int MAX_DUMMY     = 64;

  typedef enum logic [1:0] {K_IDLE, K_TX, K_RX} unit_kind_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_UNIT, S_RD, S_WR, S_END
  } seq_state_t;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] pad;
    logic [7:0] opr;
  } instr_t;
endpackage

// File: rtl/fse_table.sv
module fse_table #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  localparam int WORDS = 1 << AW;
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fse_fifo.sv
module fse_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/fse_lane_shift.sv
module fse_lane_shift
  import fse_pkg::*;
#(
  parameter int BEAT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  unit_kind_t        ld_kind,
  input  logic [1:0]        ld_lanes,
  input  logic [7:0]        ld_byte,
  input  logic [BEAT_W-1:0] ld_beats,
  input  logic [3:0]        io_in,
  output logic              busy,
  output logic              sck_en,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              rx_valid,
  output logic [7:0]        rx_byte
);
  unit_kind_t        kind;
  logic [1:0]        lanes;
  logic [7:0]        sh, in_sh, in_nxt;
  logic [BEAT_W-1:0] cnt, beats_calc;
  logic              last_q;
  logic [3:0]        chunk, oe_pat;

  assign busy = (cnt != '0) || sck_en;

  always_comb begin
    unique case (ld_lanes)
      2'd0:    beats_calc = BEAT_W'(8);
      2'd1:    beats_calc = BEAT_W'(4);
      default: beats_calc = BEAT_W'(2);
    endcase
    if (ld_kind == K_IDLE) beats_calc = ld_beats;
  end

  always_comb begin
    unique case (lanes)
      2'd0:    begin chunk = {3'b000, sh[7]};  oe_pat = 4'b0001; end
      2'd1:    begin chunk = {2'b00, sh[7:6]}; oe_pat = 4'b0011; end
      default: begin chunk = sh[7:4];          oe_pat = 4'b1111; end
    endcase
    if (kind != K_TX) begin
      chunk  = 4'b0000;
      oe_pat = 4'b0000;
    end
  end

  always_comb begin
    unique case (lanes)
      2'd0:    in_nxt = {in_sh[6:0], io_in[1]};
      2'd1:    in_nxt = {in_sh[5:0], io_in[1:0]};
      default: in_nxt = {in_sh[3:0], io_in[3:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind     <= K_IDLE;
      lanes    <= 2'd0;
      sh       <= '0;
      in_sh    <= '0;
      cnt      <= '0;
      last_q   <= 1'b0;
      sck_en   <= 1'b0;
      io_out   <= '0;
      io_oe    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (sck_en && kind == K_RX) begin
        in_sh <= in_nxt;
        if (last_q) begin
          rx_valid <= 1'b1;
          rx_byte  <= in_nxt;
        end
      end
      if (ld) begin
        kind   <= ld_kind;
        lanes  <= ld_lanes;
        sh     <= ld_byte;
        cnt    <= beats_calc;
        sck_en <= 1'b0;
        last_q <= 1'b0;
        io_out <= '0;
        io_oe  <= '0;
      end else if (cnt != '0) begin
        sck_en <= 1'b1;
        io_out <= chunk;
        io_oe  <= oe_pat;
        unique case (lanes)
          2'd0:    sh <= {sh[6:0], 1'b0};
          2'd1:    sh <= {sh[5:0], 2'b00};
          default: sh <= {sh[3:0], 4'b0000};
        endcase
        cnt    <= cnt - 1'b1;
        last_q <= (cnt == BEAT_W'(1));
      end else begin
        sck_en <= 1'b0;
        io_out <= '0;
        io_oe  <= '0;
        last_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
  import fse_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_we,
  input  logic [IDX_W+1:0] tbl_waddr,
  input  logic [31:0]      tbl_wdata,
  input  logic             cmd_we,
  input  logic [31:0]      cmd_wdata,
  output logic             busy,
  input  logic             flag_we,
  input  logic             flag_wbit,
  input  logic             irq_en,
  output logic             done,
  output logic             irq,
  input  logic             tx_push,
  input  logic [7:0]       tx_data,
  output logic             tx_full,
  input  logic             rx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_empty,
  output logic             cs_n,
  output logic             sck_en,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);
  localparam int TAW    = IDX_W + 2;
  localparam int IP_W   = $clog2(INSTR_PER_SEQ);
  localparam int BEAT_W = $clog2(MAX_DUMMY) + 1;

  seq_state_t       state;
  logic [IDX_W-1:0] seq_q;
  logic [CNT_W-1:0] cnt_q, rem_q;
  logic [IP_W-1:0]  ip_q;
  logic [1:0]       lanes_q;
  logic [31:0]      tbl_rdata;
  instr_t           ins;
  logic [1:0]       ins_lanes;

  logic              ld;
  unit_kind_t        ld_kind;
  logic [1:0]        ld_lanes;
  logic [7:0]        ld_byte;
  logic [BEAT_W-1:0] ld_beats;
  logic              sh_busy, rx_valid;
  logic [7:0]        rx_byte;
  logic              tx_pop, tx_empty;
  logic [7:0]        tx_dout;
  logic              advance, start;

  fse_table #(.AW(TAW)) u_table (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .re(state == S_FETCH), .raddr({seq_q, ip_q[IP_W-1:1]}),
    .rdata(tbl_rdata)
  );

  fse_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .din(tx_data), .pop(tx_pop),
    .dout(tx_dout), .full(tx_full), .empty(tx_empty)
  );

  fse_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_valid), .din(rx_byte), .pop(rx_pop),
    .dout(rx_data), .full(), .empty(rx_empty)
  );

  fse_lane_shift #(.BEAT_W(BEAT_W)) u_shift (
    .clk(clk), .rst(rst), .ld(ld), .ld_kind(ld_kind), .ld_lanes(ld_lanes),
    .ld_byte(ld_byte), .ld_beats(ld_beats), .io_in(io_in), .busy(sh_busy),
    .sck_en(sck_en), .io_out(io_out), .io_oe(io_oe), .rx_valid(rx_valid),
    .rx_byte(rx_byte)
  );

  assign ins       = ip_q[0] ? instr_t'(tbl_rdata[31:16]) : instr_t'(tbl_rdata[15:0]);
  assign ins_lanes = (ins.pad == 2'd3) ? 2'd2 : ins.pad;
  assign start     = (state == S_IDLE) && cmd_we;
  assign busy      = (state != S_IDLE);
  assign irq       = done && irq_en;

  always_comb begin
    ld       = 1'b0;
    ld_kind  = K_IDLE;
    ld_lanes = lanes_q;
    ld_byte  = 8'h00;
    ld_beats = '0;
    tx_pop   = 1'b0;
    advance  = 1'b0;
    unique case (state)
      S_DECODE: begin
        ld_lanes = ins_lanes;
        ld_byte  = ins.opr;
        unique case (ins.op)
          OP_CMD, OP_ADDR, OP_MODE: begin
            ld      = 1'b1;
            ld_kind = K_TX;
          end
          OP_DUMMY: begin
            ld       = (ins.opr != 8'd0);
            ld_kind  = K_IDLE;
            ld_beats = (ins.opr > 8'(MAX_DUMMY)) ? BEAT_W'(MAX_DUMMY)
                                                  : BEAT_W'(ins.opr);
          end
          default: ;
        endcase
      end
      S_UNIT: advance = !sh_busy;
      S_RD: begin
        if (!sh_busy) begin
          if (rem_q == '0) advance = 1'b1;
          else begin
            ld      = 1'b1;
            ld_kind = K_RX;
          end
        end
      end
      S_WR: begin
        if (!sh_busy) begin
          if (rem_q == '0) advance = 1'b1;
          else if (!tx_empty) begin
            ld      = 1'b1;
            ld_kind = K_TX;
            ld_byte = tx_dout;
            tx_pop  = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      seq_q   <= '0;
      cnt_q   <= '0;
      rem_q   <= '0;
      ip_q    <= '0;
      lanes_q <= 2'd0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      if (flag_we && flag_wbit) done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            seq_q <= cmd_wdata[24 +: IDX_W];
            cnt_q <= cmd_wdata[CNT_W-1:0];
            ip_q  <= '0;
            cs_n  <= 1'b0;
            state <= S_FETCH;
          end
        end
        S_FETCH: state <= S_DECODE;
        S_DECODE: begin
          lanes_q <= ins_lanes;
          rem_q   <= cnt_q;
          unique case (ins.op)
            OP_CMD, OP_ADDR, OP_MODE, OP_DUMMY: state <= S_UNIT;
            OP_READ:  state <= S_RD;
            OP_WRITE: state <= S_WR;
            default:  state <= S_END;
          endcase
        end
        S_UNIT, S_RD, S_WR: begin
          if (ld && state != S_UNIT) rem_q <= rem_q - 1'b1;
          if (advance) begin
            if (ip_q == IP_W'(INSTR_PER_SEQ-1)) state <= S_END;
            else begin
              ip_q  <= ip_q + 1'b1;
              state <= S_FETCH;
            end
          end
        end
        S_END: begin
          cs_n  <= 1'b1;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fse_checker.sv
module fse_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmd_we,
  input logic       busy,
  input logic       flag_we,
  input logic       flag_wbit,
  input logic       done,
  input logic       cs_n,
  input logic       sck_en,
  input logic [3:0] io_oe
);
  AST_SCK_INSIDE_CS: assert property (@(posedge clk) disable iff (rst) sck_en |-> !cs_n); // R10
  AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst) cs_n |-> (io_oe == 4'b0000)); // R10
  AST_OE_LEGAL_LANES: assert property (@(posedge clk) disable iff (rst) (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111)); // R3
  AST_CS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst) !cs_n |-> busy); // R9
  AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(cmd_we)); // R2
  AST_RELEASE_SETS_DONE: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> done); // R8
  AST_DONE_CLEAR_BY_W1: assert property (@(posedge clk) disable iff (rst) $fell(done) |-> $past(flag_we && flag_wbit)); // R8
endmodule

bind flash_seq_engine fse_checker u_fse_checker (
  .clk(clk), .rst(rst), .cmd_we(cmd_we), .busy(busy), .flag_we(flag_we),
  .flag_wbit(flag_wbit), .done(done), .cs_n(cs_n), .sck_en(sck_en),
  .io_oe(io_oe)
);

// File: tb/flash_seq_engine_tb.sv
module flash_seq_engine_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 0; logic [5:0] tbl_waddr = 0; logic [31:0] tbl_wdata = 0;
  logic cmd_we = 0; logic [31:0] cmd_wdata = 0;
  logic busy, done, irq, tx_full, rx_empty, cs_n, sck_en;
  logic flag_we = 0, flag_wbit = 0, irq_en = 0, tx_push = 0, rx_pop = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic [3:0] io_out, io_oe, io_in;

  always #10 clk = ~clk;

  flash_seq_engine u_dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .busy(busy), .flag_we(flag_we), .flag_wbit(flag_wbit), .irq_en(irq_en),
    .done(done), .irq(irq), .tx_push(tx_push), .tx_data(tx_data),
    .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_empty(rx_empty), .cs_n(cs_n), .sck_en(sck_en), .io_out(io_out),
    .io_oe(io_oe), .io_in(io_in)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  int nb = 0;
  logic [3:0] b_out [512];
  logic [3:0] b_oe  [512];
  int rd_start = 100000;
  int rd_pad = 0;
  logic [7:0] rd_bytes [8];

  // Beat recorder and flash read model: drive io_in mid-cycle of each read beat.
  always @(negedge clk) begin
    io_in = 4'b0000;
    if (sck_en) begin
      if (nb < 512) begin
        b_out[nb] = io_out;
        b_oe[nb]  = io_oe;
      end
      if (nb >= rd_start) begin
        int w, bpb, off, k, pos;
        logic [7:0] v;
        w   = 1 << rd_pad;
        bpb = 8 / w;
        off = nb - rd_start;
        k   = off / bpb;
        pos = off % bpb;
        v   = (k < 8) ? rd_bytes[k] : 8'h00;
        v   = v >> (8 - w * (pos + 1));
        if (rd_pad == 0)      io_in = {2'b00, v[0], 1'b0};
        else if (rd_pad == 1) io_in = {2'b00, v[1:0]};
        else                  io_in = v[3:0];
      end
      nb = nb + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int pad, input int opr);
    return {6'(op), 2'(pad), 8'(opr)};
  endfunction

  function automatic logic [7:0] beat_byte(input int s, input int pad);
    logic [7:0] v = 0;
    int w = 1 << pad;
    for (int i = 0; i < 8 / w; i++) begin
      if (pad == 0)      v = {v[6:0], b_out[s+i][0]};
      else if (pad == 1) v = {v[5:0], b_out[s+i][1:0]};
      else               v = {v[3:0], b_out[s+i]};
    end
    return v;
  endfunction

  task automatic load_seq(input int idx, input logic [15:0] p [8]);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tbl_we = 1; tbl_waddr = 6'(idx * 4 + k); tbl_wdata = {p[2*k+1], p[2*k]};
    end
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic start_seq(input int idx, input int cnt);
    @(negedge clk);
    nb = 0;
    cmd_we = 1; cmd_wdata = {8'(idx), 16'h0, 8'(cnt)};
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_push = 1; tx_data = b;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string tag);
    chk(!rx_empty && rx_data == exp, tag, rx_data, exp);
    rx_pop = 1; @(negedge clk); rx_pop = 0;
  endtask

  task automatic t_reset();
    chk(cs_n === 1'b1 && sck_en === 1'b0 && io_oe === 4'b0, "R10 reset pins", {cs_n, sck_en, io_oe}, 6'b100000);
    chk(busy === 1'b0 && done === 1'b0 && irq === 1'b0, "R9 reset status", {busy, done, irq}, 0);
  endtask

  task automatic t_single_read();
    logic [15:0] p [8] = '{ins(1,0,8'h9F), ins(7,0,0), ins(0,0,0), 0, 0, 0, 0, 0};
    load_seq(1, p);
    rd_pad = 0; rd_start = 8;
    rd_bytes[0] = 8'hC2; rd_bytes[1] = 8'h20; rd_bytes[2] = 8'h17;
    start_seq(1, 3);
    chk(busy === 1'b1 && cs_n === 1'b0, "R2 start busy", {busy, cs_n}, 2'b10);
    wait_idle();
    rd_start = 100000;
    chk(nb == 32, "R5 single read beat count", nb, 32);
    chk(beat_byte(0, 0) == 8'h9F && b_oe[0] == 4'b0001, "R3 single lane cmd", beat_byte(0, 0), 8'h9F);
    chk(b_oe[8] == 4'b0000, "R5 read lines undriven", b_oe[8], 0);
    pop_chk(8'hC2, "R5 read byte0");
    pop_chk(8'h20, "R5 read byte1");
    pop_chk(8'h17, "R5 read byte2");
    chk(cs_n === 1'b1 && done === 1'b1 && busy === 1'b0, "R7 R8 end state", {cs_n, done, busy}, 3'b110);
  endtask

  task automatic t_flag();
    chk(irq === 1'b0, "R8 irq masked", irq, 0);
    irq_en = 1; @(negedge clk);
    chk(irq === 1'b1, "R8 irq enabled", irq, 1);
    flag_we = 1; flag_wbit = 0; @(negedge clk); flag_we = 0; @(negedge clk);
    chk(done === 1'b1, "R8 write 0 keeps flag", done, 1);
    flag_we = 1; flag_wbit = 1; @(negedge clk); flag_we = 0; @(negedge clk);
    chk(done === 1'b0 && irq === 1'b0, "R8 write 1 clears", {done, irq}, 0);
    irq_en = 0;
  endtask

  task automatic t_quad_read();
    logic [15:0] p [8] = '{ins(1,0,8'hEB), ins(2,2,8'h12), ins(2,2,8'h34), ins(4,2,8'hA5),
                           ins(3,2,4), ins(7,2,0), ins(0,0,0), 0};
    load_seq(2, p);
    rd_pad = 2; rd_start = 18;
    rd_bytes[0] = 8'h5E; rd_bytes[1] = 8'hB7;
    start_seq(2, 2);
    wait_idle();
    rd_start = 100000;
    chk(nb == 22, "R1 R4 quad beat count", nb, 22);
    chk(beat_byte(8, 2) == 8'h12 && b_oe[8] == 4'b1111, "R3 quad addr0", beat_byte(8, 2), 8'h12);
    chk(beat_byte(10, 2) == 8'h34, "R1 odd-slot addr1", beat_byte(10, 2), 8'h34);
    chk(beat_byte(12, 2) == 8'hA5, "R3 quad mode byte", beat_byte(12, 2), 8'hA5);
    chk(b_oe[14] == 0 && b_oe[17] == 0, "R4 dummy undriven", {b_oe[14], b_oe[17]}, 0);
    pop_chk(8'h5E, "R5 quad read byte0");
    pop_chk(8'hB7, "R5 quad read byte1");
  endtask

  task automatic t_dual_write();
    logic [15:0] p [8] = '{ins(1,1,8'h02), ins(8,1,0), ins(0,0,0), 0, 0, 0, 0, 0};
    load_seq(3, p);
    push_tx(8'h3C); push_tx(8'h81); push_tx(8'hE4);
    start_seq(3, 3);
    wait_idle();
    chk(nb == 16, "R6 dual write beat count", nb, 16);
    chk(beat_byte(0, 1) == 8'h02 && b_oe[0] == 4'b0011, "R3 dual cmd", beat_byte(0, 1), 8'h02);
    chk(beat_byte(4, 1) == 8'h3C, "R6 write byte0", beat_byte(4, 1), 8'h3C);
    chk(beat_byte(8, 1) == 8'h81, "R6 write byte1", beat_byte(8, 1), 8'h81);
    chk(beat_byte(12, 1) == 8'hE4 && b_oe[12] == 4'b0011, "R6 write byte2", beat_byte(12, 1), 8'hE4);
  endtask

  task automatic t_write_stall();
    logic [15:0] p [8] = '{ins(8,0,0), ins(0,0,0), 0, 0, 0, 0, 0, 0};
    load_seq(4, p);
    start_seq(4, 1);
    repeat (20) @(negedge clk);
    chk(nb == 0 && busy === 1'b1, "R6 stall on empty tx", nb, 0);
    push_tx(8'hC3);
    wait_idle();
    chk(nb == 8 && beat_byte(0, 0) == 8'hC3, "R6 resume after push", beat_byte(0, 0), 8'hC3);
  endtask

  task automatic t_endings();
    logic [15:0] p [8];
    for (int i = 0; i < 8; i++) p[i] = ins(1, 2, 8'h10 + i);
    load_seq(5, p);
    start_seq(5, 0);
    wait_idle();
    chk(nb == 16 && cs_n === 1'b1, "R7 end after instr 7", nb, 16);
    chk(beat_byte(14, 2) == 8'h17, "R1 last slot sent", beat_byte(14, 2), 8'h17);
    p = '{ins(1,0,8'h66), ins(5,0,0), ins(1,0,8'h99), 0, 0, 0, 0, 0};
    load_seq(6, p);
    start_seq(6, 0);
    wait_idle();
    chk(nb == 8 && beat_byte(0, 0) == 8'h66, "R7 unknown opcode stops", nb, 8);
  endtask

  task automatic t_dummy_busy_cmd();
    logic [15:0] p [8] = '{ins(3,0,200), ins(3,0,0), ins(1,0,8'h5A), ins(0,0,0), 0, 0, 0, 0};
    load_seq(7, p);
    start_seq(7, 0);
    repeat (5) @(negedge clk);
    cmd_we = 1; cmd_wdata = {8'd1, 16'h0, 8'd3};
    @(negedge clk); cmd_we = 0;
    wait_idle();
    chk(nb == 72, "R4 dummy capped at 64, zero skipped", nb, 72);
    chk(beat_byte(64, 0) == 8'h5A, "R4 cmd after dummy", beat_byte(64, 0), 8'h5A);
    repeat (10) @(negedge clk);
    chk(busy === 1'b0 && nb == 72, "R2 command while busy ignored", busy, 0);
  endtask

  task automatic t_zero_count();
    logic [15:0] p [8] = '{ins(1,0,8'hAB), ins(7,0,0), ins(8,0,0), ins(0,0,0), 0, 0, 0, 0};
    load_seq(8, p);
    push_tx(8'h77);
    start_seq(8, 0);
    wait_idle();
    chk(nb == 8, "R11 zero count no beats", nb, 8);
    chk(rx_empty === 1'b1, "R11 no rx bytes", rx_empty, 1);
    start_seq(3, 1);
    wait_idle();
    chk(beat_byte(4, 1) == 8'h77, "R11 tx byte untouched", beat_byte(4, 1), 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single_read();
    t_flag();
    t_quad_read();
    t_dual_write();
    t_write_stall();
    t_endings();
    t_dummy_busy_cmd();
    t_zero_count();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule